// File: doc/BRIEF.md
# SDRAM Bring-up and Refresh Sequencer

This block owns the command pins of a single-data-rate SDRAM from reset until the memory is usable. It then keeps the memory alive with periodic refresh. After reset it holds the bus at NOP for a programmable pause, then issues one PRECHARGE ALL, a burst of auto-refresh commands and one mode-register load. Each gap between these commands is an exact number of clock cycles. When the last gap has run out it raises a done flag and stays there until the next reset.

In normal operation a reloadable interval counter raises a refresh request. The request stays up until the arbiter grants it. On the grant the block drives one AUTO REFRESH command and restarts the interval. All timings are clock-cycle counts set by parameters. The defaults suit a 100 MHz clock: a 200 µs pause, a 15.625 µs refresh interval, tRP of 5, tRFC of 13, tMRD of 2, CAS latency 3 and a bank address one bit wide.

Top module: `sdr_bringup_seq`

## Requirements
- R1: While reset is high the pins carry NOP (csN,rasN,casN,weN = 0,1,1,1), the address and bank are 0, and initDone and refreshReq are low.
- R2: The first command other than NOP is PRECHARGE ALL (0,0,1,0), with address bit 10 high, all other address bits 0 and bank 0. It is driven in the cycle that follows the PAUSE_CYC-th rising edge after reset release.
- R3: The first AUTO REFRESH (0,0,0,1, address 0, bank 0) appears exactly T_RP cycles after the PRECHARGE ALL cycle.
- R4: Exactly INIT_REFS AUTO REFRESH commands are issued during bring-up, each T_RFC cycles after the one before.
- R5: LOAD MODE REGISTER (0,0,0,0) appears T_RFC cycles after the last bring-up refresh. Its bank is 0 and its address is CAS_LAT in bits 6:4 with all other bits 0, which selects burst length 1 and sequential burst type.
- R6: Every command lasts one cycle, and every cycle that carries no command carries NOP.
- R7: initDone rises exactly T_MRD cycles after the mode-load cycle and stays high until reset.
- R8: refreshReq first rises exactly REF_INTERVAL cycles after initDone rises.
- R9: refreshReq stays high until refGrant is sampled high. At that edge refreshReq falls, the next cycle carries AUTO REFRESH, and the request rises again REF_INTERVAL cycles after that edge.
- R10: refGrant while refreshReq is low, including during bring-up, issues no command and does not move the bring-up schedule or the request timing.
- R11: Reset asserted at any point restarts the whole sequence from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| refGrant | input | 1 | Permission to issue the pending refresh |
| sdrCsN | output | 1 | Chip select, active low |
| sdrRasN | output | 1 | Row strobe, active low |
| sdrCasN | output | 1 | Column strobe, active low |
| sdrWeN | output | 1 | Write enable, active low |
| sdrBa | output | BA_W | Bank address |
| sdrAddr | output | ADDR_W | Address bus |
| initDone | output | 1 | Bring-up finished |
| refreshReq | output | 1 | Refresh due, held until granted |

## Verification
The bench builds the block with PAUSE_CYC 20, T_RP 3, T_RFC 4, T_MRD 2, eight bring-up refreshes and REF_INTERVAL 10. With these values the whole bring-up takes under sixty cycles. The bench compares every cycle of it against a schedule it computes arithmetically. The short interval lets the bench sweep the grant delay from zero to five cycles after a request, and mix stray grants in while no request is pending. A reset part way through bring-up checks the restart, with geometry left at its defaults.

// File: rtl/sdr_bringup_pkg.sv
package sdr_bringup_pkg;

  typedef enum logic [1:0] {CMD_NOP, CMD_PRE, CMD_REF, CMD_MRS} cmdKind_e;
  typedef enum logic [1:0] {GAP_NONE, GAP_RP, GAP_RFC, GAP_MRD} gapSel_e;

  typedef struct packed {
    cmdKind_e cmdKind;
    gapSel_e  gapSel;
    logic     finish;
    logic     reloadRef;
  } seqStrobe_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] PINS_NOP = 4'b0111;
  localparam logic [3:0] PINS_PRE = 4'b0010;
  localparam logic [3:0] PINS_REF = 4'b0001;
  localparam logic [3:0] PINS_MRS = 4'b0000;

endpackage

// File: rtl/sdr_bringup_ctrl.sv
module sdr_bringup_ctrl
  import sdr_bringup_pkg::*;
#(
  parameter int INIT_REFS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       waitDone,
  input  logic       refDue,
  input  logic       refGrant,
  output seqStrobe_t strobe
);
  localparam int REFS_W = $clog2(INIT_REFS + 1);

  typedef enum logic [2:0] {ST_PAUSE, ST_PRE_GAP, ST_REF_GAP, ST_MRS_GAP, ST_RUN} state_e;

  state_e            state, stateNext;
  logic [REFS_W-1:0] refLeft, refLeftNext;

  always_comb begin
    strobe      = '{cmdKind: CMD_NOP, gapSel: GAP_NONE, finish: 1'b0, reloadRef: 1'b0};
    stateNext   = state;
    refLeftNext = refLeft;
    unique case (state)
      ST_PAUSE: if (waitDone) begin
        strobe.cmdKind = CMD_PRE;
        strobe.gapSel  = GAP_RP;
        stateNext      = ST_PRE_GAP;
      end
      ST_PRE_GAP: if (waitDone) begin
        strobe.cmdKind = CMD_REF;
        strobe.gapSel  = GAP_RFC;
        refLeftNext    = REFS_W'(INIT_REFS - 1);
        stateNext      = ST_REF_GAP;
      end
      ST_REF_GAP: if (waitDone) begin
        if (refLeft != '0) begin
          strobe.cmdKind = CMD_REF;
          strobe.gapSel  = GAP_RFC;
          refLeftNext    = refLeft - 1'b1;
        end else begin
          strobe.cmdKind = CMD_MRS;
          strobe.gapSel  = GAP_MRD;
          stateNext      = ST_MRS_GAP;
        end
      end
      ST_MRS_GAP: if (waitDone) begin
        strobe.finish = 1'b1;
        stateNext     = ST_RUN;
      end
      ST_RUN: if (refGrant && refDue) begin
        strobe.cmdKind   = CMD_REF;
        strobe.reloadRef = 1'b1;
      end
      default: stateNext = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_PAUSE;
      refLeft <= '0;
    end else begin
      state   <= stateNext;
      refLeft <= refLeftNext;
    end
  end

endmodule

// File: rtl/sdr_bringup_dp.sv
module sdr_bringup_dp
  import sdr_bringup_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int T_RP         = 5,
  parameter int T_RFC        = 13,
  parameter int T_MRD        = 2,
  parameter int REF_INTERVAL = 1562,
  parameter int CAS_LAT      = 3,
  parameter int ADDR_W       = 11,
  parameter int BA_W         = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  output logic              waitDone,
  output logic              refDue,
  output logic [3:0]        pins,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);
  localparam int GAP_MAX  = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                           : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
  localparam int WAIT_MAX = (PAUSE_CYC > GAP_MAX) ? PAUSE_CYC : GAP_MAX;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int REF_W    = $clog2(REF_INTERVAL + 1);
  localparam logic [ADDR_W-1:0] PRE_WORD  = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(CAS_LAT) << 4;

  logic [WAIT_W-1:0] waitCnt;
  logic [REF_W-1:0]  refCnt;
  logic              refReq;
  logic [3:0]        pinsNext;
  logic [ADDR_W-1:0] addrNext;

  assign waitDone = (waitCnt == '0);
  assign refDue   = refReq;

  always_comb begin
    pinsNext = PINS_NOP;
    addrNext = '0;
    unique case (strobe.cmdKind)
      CMD_PRE: begin pinsNext = PINS_PRE; addrNext = PRE_WORD;  end
      CMD_REF: begin pinsNext = PINS_REF; addrNext = '0;        end
      CMD_MRS: begin pinsNext = PINS_MRS; addrNext = MODE_WORD; end
      default: begin pinsNext = PINS_NOP; addrNext = '0;        end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waitCnt  <= WAIT_W'(PAUSE_CYC - 1);
      pins     <= PINS_NOP;
      addr     <= '0;
      ba       <= '0;
      initDone <= 1'b0;
      refCnt   <= '0;
      refReq   <= 1'b0;
    end else begin
      unique case (strobe.gapSel)
        GAP_RP:  waitCnt <= WAIT_W'(T_RP - 1);
        GAP_RFC: waitCnt <= WAIT_W'(T_RFC - 1);
        GAP_MRD: waitCnt <= WAIT_W'(T_MRD - 1);
        default: if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
      endcase
      pins <= pinsNext;
      addr <= addrNext;
      ba   <= '0;
      if (strobe.finish) begin
        initDone <= 1'b1;
        refCnt   <= REF_W'(REF_INTERVAL - 1);
      end else if (strobe.reloadRef) begin
        refReq <= 1'b0;
        refCnt <= REF_W'(REF_INTERVAL - 1);
      end else if (initDone) begin
        if (refCnt != '0) refCnt <= refCnt - 1'b1;
        else              refReq <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdr_bringup_seq.sv
module sdr_bringup_seq
  import sdr_bringup_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int T_RP         = 5,
  parameter int T_RFC        = 13,
  parameter int T_MRD        = 2,
  parameter int INIT_REFS    = 8,
  parameter int REF_INTERVAL = 1562,
  parameter int CAS_LAT      = 3,
  parameter int ADDR_W       = 11,
  parameter int BA_W         = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refGrant,
  output logic              sdrCsN,
  output logic              sdrRasN,
  output logic              sdrCasN,
  output logic              sdrWeN,
  output logic [BA_W-1:0]   sdrBa,
  output logic [ADDR_W-1:0] sdrAddr,
  output logic              initDone,
  output logic              refreshReq
);
  seqStrobe_t strobe;
  logic       waitDone;
  logic [3:0] pins;

  sdr_bringup_ctrl #(.INIT_REFS(INIT_REFS)) u_ctrl (
    .clk(clk), .rst(rst), .waitDone(waitDone), .refDue(refreshReq),
    .refGrant(refGrant), .strobe(strobe)
  );

  sdr_bringup_dp #(
    .PAUSE_CYC(PAUSE_CYC), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .REF_INTERVAL(REF_INTERVAL), .CAS_LAT(CAS_LAT), .ADDR_W(ADDR_W), .BA_W(BA_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .waitDone(waitDone),
    .refDue(refreshReq), .pins(pins), .ba(sdrBa), .addr(sdrAddr),
    .initDone(initDone)
  );

  assign {sdrCsN, sdrRasN, sdrCasN, sdrWeN} = pins;

endmodule

// File: rtl/sdr_bringup_seq_chk.sv
module sdr_bringup_seq_chk
  import sdr_bringup_pkg::*;
#(
  parameter int T_RFC  = 13,
  parameter int ADDR_W = 11,
  parameter int BA_W   = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              refGrant,
  input logic              sdrCsN,
  input logic              sdrRasN,
  input logic              sdrCasN,
  input logic              sdrWeN,
  input logic [BA_W-1:0]   sdrBa,
  input logic [ADDR_W-1:0] sdrAddr,
  input logic              initDone,
  input logic              refreshReq
);
  localparam int CW = $clog2(T_RFC + 1) + 1;

  logic [3:0]    pins;
  logic [CW-1:0] sinceRef;
  assign pins = {sdrCsN, sdrRasN, sdrCasN, sdrWeN};

  always_ff @(posedge clk) begin
    if (rst)                       sinceRef <= '1;
    else if (pins == PINS_REF)     sinceRef <= CW'(1);
    else if (sinceRef != '1)       sinceRef <= sinceRef + 1'b1;
  end

  p_pre_a10_r2: assert property (@(posedge clk) disable iff (rst)
    (pins == PINS_PRE) |-> (sdrAddr[10] && sdrBa == '0));
  p_ref_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    (pins == PINS_REF) |-> (sinceRef >= CW'(T_RFC)));
  p_mrs_bank_r5: assert property (@(posedge clk) disable iff (rst)
    (pins == PINS_MRS) |-> (sdrBa == '0 && sdrAddr[3:0] == 4'd0));
  p_cmd_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    (pins != PINS_NOP) |=> (pins == PINS_NOP));
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone);
  p_req_needs_done_r8: assert property (@(posedge clk) disable iff (rst)
    refreshReq |-> initDone);
  p_req_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (refreshReq && !refGrant) |=> refreshReq);
  p_grant_refreshes_r9: assert property (@(posedge clk) disable iff (rst)
    (refreshReq && refGrant) |=> (!refreshReq && pins == PINS_REF));
  p_idle_grant_r10: assert property (@(posedge clk) disable iff (rst)
    (initDone && !refreshReq && refGrant) |=> (pins == PINS_NOP));

endmodule

bind sdr_bringup_seq sdr_bringup_seq_chk #(.T_RFC(T_RFC), .ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst(rst), .refGrant(refGrant), .sdrCsN(sdrCsN), .sdrRasN(sdrRasN),
  .sdrCasN(sdrCasN), .sdrWeN(sdrWeN), .sdrBa(sdrBa), .sdrAddr(sdrAddr),
  .initDone(initDone), .refreshReq(refreshReq)
);

// File: tb/sdr_bringup_seq_test.sv
module sdr_bringup_seq_test;
  localparam int PAUSE = 20, TRP = 3, TRFC = 4, TMRD = 2, NREF = 8, RINT = 10;
  localparam int FIRST_REF = PAUSE + TRP;
  localparam int LAST_REF  = FIRST_REF + (NREF - 1) * TRFC;
  localparam int MRS_CYC   = LAST_REF + TRFC;
  localparam int DONE_CYC  = MRS_CYC + TMRD;

  logic clk = 1'b0, rst = 1'b1, refGrant = 1'b0;
  logic sdrCsN, sdrRasN, sdrCasN, sdrWeN, initDone, refreshReq;
  logic [0:0]  sdrBa;
  logic [10:0] sdrAddr;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sdr_bringup_seq #(.PAUSE_CYC(PAUSE), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
    .INIT_REFS(NREF), .REF_INTERVAL(RINT)) uut (
    .clk(clk), .rst(rst), .refGrant(refGrant), .sdrCsN(sdrCsN), .sdrRasN(sdrRasN),
    .sdrCasN(sdrCasN), .sdrWeN(sdrWeN), .sdrBa(sdrBa), .sdrAddr(sdrAddr),
    .initDone(initDone), .refreshReq(refreshReq));

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pinsNow();
    return {sdrCsN, sdrRasN, sdrCasN, sdrWeN};
  endfunction

  task automatic runPass(int pass, int stopAt);
    int nextReq, reqRise, epoch, dly, expPins, expAddr;
    bit mReq, gnt, take;
    string tag;
    rst = 1'b1; refGrant = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pins", pinsNow(), 'h7);
    chk("R1 addr", int'(sdrAddr), 0);
    chk("R1 done", int'(initDone), 0);
    chk("R1 req", int'(refreshReq), 0);
    rst = 1'b0;
    mReq = 0; nextReq = DONE_CYC + RINT; reqRise = 0; epoch = 0; dly = 0;
    for (int c = 1; c <= stopAt; c++) begin
      if (c - 1 >= DONE_CYC) gnt = mReq ? ((c - 1 - reqRise) == dly) : ((c - 1) % 4 == 1);
      else                   gnt = (c % 3 == 1);
      refGrant = gnt;
      @(posedge clk); @(negedge clk);
      take = gnt && mReq;
      expPins = 'h7; expAddr = 0; tag = "R6 nop";
      if (take) begin
        expPins = 'h1; tag = "R9 grant"; mReq = 0; nextReq = c + RINT;
        epoch++; dly = epoch % 6;
      end else if (c == PAUSE) begin
        expPins = 'h2; expAddr = 'h400; tag = (pass == 2) ? "R11 restart" : "R2 precharge";
      end else if (c >= FIRST_REF && c <= LAST_REF && (c - FIRST_REF) % TRFC == 0) begin
        expPins = 'h1; tag = (c == FIRST_REF) ? "R3 first ref" : "R4 init ref";
      end else if (c == MRS_CYC) begin
        expPins = 'h0; expAddr = 'h030; tag = "R5 mode load";
      end else if (gnt) tag = "R10 stray grant";
      if (!take && c >= DONE_CYC && c >= nextReq) begin
        if (!mReq) reqRise = c;
        mReq = 1;
      end
      chk(tag, pinsNow(), expPins);
      chk(tag, int'(sdrAddr), expAddr);
      chk("R5 bank", int'(sdrBa), 0);
      chk("R7 done", int'(initDone), int'(c >= DONE_CYC));
      chk((epoch == 0) ? "R8 first req" : "R9 req", int'(refreshReq), int'(mReq));
    end
    refGrant = 1'b0;
  endtask

  initial begin
    runPass(1, 35);
    runPass(2, DONE_CYC + 120);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule